// File: doc/BRIEF.md
# Departure Timestamp Allocator

This block gives every flit entering a five-port router a departure cycle: the future cycle in which the flit leaves the router's internal buffering toward the output it asked for. The cycle is chosen as if the router held every flit in a queue at its output port. Each output keeps its own record of the latest slot it has handed out. A free-running cycle count gives the current time. The block arbitrates for nothing in the present cycle. It reserves a future slot on the output link, so that flits bound for one output leave strictly in arrival order and the link stays busy while any of them wait.

Every input may request in every cycle. When several inputs name the same output in one cycle, they receive consecutive slots, and the lowest input index gets the earliest one. A later pipeline stage may fail to place a flit. It then cancels that flit's allocation, and the flit asks again from its input buffer in a later cycle. A cancelled slot is returned only when it is still the newest slot of its output. All times are 8-bit values that wrap, and they are compared modulo 256.

Top module: `ts_alloc_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `grant_valid` is all zero and `now` reads 0.
- R2: `now` rises by one in every cycle after reset and wraps from 255 to 0.
- R3: A request sampled at a clock edge is answered at that same edge, so the answer is visible in the following cycle. A request to an output with no future slot pending gets slot `now + 1`, where `now` is the value sampled at that edge.
- R4: A request to an output that has a pending slot T gets slot T + 1, so a flit never receives an earlier slot than one granted before it to the same output.
- R5: Inputs that request the same output at the same edge get consecutive slots, in ascending order of input index.
- R6: Outputs are independent. Slots given on one output never change the slots given on another.
- R7: A slot lying more than 64 cycles past the sampled `now` is refused (grant low). A refused request consumes no slot.
- R8: A cancel for output P that carries P's newest slot, while that slot is still in the future, returns the slot. The next request to P receives it again.
- R9: A cancel that carries any slot other than the newest pending slot of its output has no effect. The next request gets the newest slot plus one.
- R10: Slot numbers wrap modulo 256 with no change in ordering or spacing when `now` or the slots pass 255.
- R11: Output codes are 0 to 4 (0 local, 1 north, 2 east, 3 south, 4 west). A request carrying a code of 5, 6 or 7 is never granted and consumes nothing.
- R12: When a cancel and new requests reach the same output at the same edge, the cancel takes effect first, so the new requests may reuse the returned slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 5 | One request strobe per input |
| req_port | input | 15 | Requested output code of input i in bits [3i+2:3i] |
| cancel_valid | input | 1 | Cancels one earlier allocation |
| cancel_port | input | 3 | Output code of the cancelled allocation |
| cancel_ts | input | 8 | Slot of the cancelled allocation |
| now | output | 8 | Free-running current time |
| grant_valid | output | 5 | Registered grant per input |
| grant_ts | output | 40 | Registered slot of input i in bits [8i+7:8i] |

## Verification
The block is driven with the following patterns:
- A lone request to an idle output, which tells the now-plus-one base apart from the pending-slot base.
- Five-way same-cycle bursts to one output, which expose the ordering by input index.
- Simultaneous requests to different outputs, which show that per-output state does not leak between outputs.
- Cancels aimed at the newest slot, at an older slot, and in the same cycle as a new request, which separate slot release from a lost slot and show the order in which a cancel and a request are applied.
- Sustained bursts to one output, which reach the 64-slot cap and show that refused requests consume nothing.
- A long mixed run across the 255-to-0 boundary, which catches modular-arithmetic faults.

// File: rtl/ts_alloc_pkg.sv
package ts_alloc_pkg;
  localparam int PORT_W = 3;

  typedef enum logic [PORT_W-1:0] {
    PT_LOCAL = 3'd0,
    PT_NORTH = 3'd1,
    PT_EAST  = 3'd2,
    PT_SOUTH = 3'd3,
    PT_WEST  = 3'd4
  } port_e;
endpackage

// File: rtl/ts_clock.sv
module ts_clock #(
  parameter int TS_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] now
);
  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else     now <= now + 1'b1;
  end

  AST_NOW_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> now == TS_W'($past(now) + 1'b1)); // R2
endmodule

// File: rtl/ts_out_alloc.sv
module ts_out_alloc #(
  parameter int NUM_IN = 5,
  parameter int TS_W   = 8,
  parameter int CAP    = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [TS_W-1:0]        now,
  input  logic [NUM_IN-1:0]      match,
  input  logic                   cxl_hit,
  input  logic [TS_W-1:0]        cxl_ts,
  output logic [NUM_IN-1:0]      grant,
  output logic [NUM_IN*TS_W-1:0] slot_flat
);
  localparam logic [TS_W-1:0] CAP_V = TS_W'(CAP);

  logic            act_q, act_c, act_n;
  logic [TS_W-1:0] tail_q, tail_c, tail_n;
  logic [TS_W-1:0] base, cnt, slot, ahead;
  logic            rel;

  always_comb begin
    // cancel is applied before the new requests of the same cycle
    rel    = cxl_hit && act_q && (cxl_ts == tail_q) && (tail_q != now);
    act_c  = act_q;
    tail_c = tail_q;
    if (rel) begin
      if (TS_W'(tail_q - now) == TS_W'(1)) act_c  = 1'b0;
      else                                 tail_c = tail_q - 1'b1;
    end
    base      = act_c ? tail_c + 1'b1 : now + 1'b1;
    cnt       = '0;
    grant     = '0;
    slot_flat = '0;
    slot      = '0;
    ahead     = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      slot  = base + cnt;
      ahead = slot - now;
      slot_flat[i*TS_W +: TS_W] = slot;
      if (match[i] && (ahead <= CAP_V)) begin
        grant[i] = 1'b1;
        cnt      = cnt + 1'b1;
      end
    end
    if (cnt != '0) begin
      act_n  = 1'b1;
      tail_n = base + cnt - 1'b1;
    end else begin
      act_n  = act_c;
      tail_n = tail_c;
    end
    if (act_n && (tail_n == now)) act_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      tail_q <= '0;
    end else begin
      act_q  <= act_n;
      tail_q <= tail_n;
    end
  end

  AST_CAP_HELD: assert property (@(posedge clk) disable iff (rst)
    act_q |-> TS_W'(tail_q - now) <= CAP_V); // R7

  AST_TAIL_FWD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rel) && act_q && $past(act_q))
      |-> TS_W'(tail_q - $past(tail_q)) <= TS_W'(NUM_IN)); // R4
endmodule

// File: rtl/ts_alloc_top.sv
module ts_alloc_top
  import ts_alloc_pkg::*;
#(
  parameter int NUM_IN  = 5,
  parameter int NUM_OUT = 5,
  parameter int TS_W    = 8,
  parameter int CAP     = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_IN-1:0]        req_valid,
  input  logic [NUM_IN*PORT_W-1:0] req_port,
  input  logic                     cancel_valid,
  input  logic [PORT_W-1:0]        cancel_port,
  input  logic [TS_W-1:0]          cancel_ts,
  output logic [TS_W-1:0]          now,
  output logic [NUM_IN-1:0]        grant_valid,
  output logic [NUM_IN*TS_W-1:0]   grant_ts
);
  logic [NUM_OUT-1:0][NUM_IN-1:0]      match;
  logic [NUM_OUT-1:0][NUM_IN-1:0]      og;
  logic [NUM_OUT-1:0][NUM_IN*TS_W-1:0] os;
  logic [NUM_IN-1:0]                   gv_c;
  logic [NUM_IN*TS_W-1:0]              ts_c;

  ts_clock #(.TS_W(TS_W)) u_clock (.clk(clk), .rst(rst), .now(now));

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    for (genvar i = 0; i < NUM_IN; i++) begin : g_dec
      assign match[o][i] = req_valid[i] && (req_port[i*PORT_W +: PORT_W] == PORT_W'(o));
    end
    ts_out_alloc #(.NUM_IN(NUM_IN), .TS_W(TS_W), .CAP(CAP)) u_alloc (
      .clk      (clk),
      .rst      (rst),
      .now      (now),
      .match    (match[o]),
      .cxl_hit  (cancel_valid && (cancel_port == PORT_W'(o))),
      .cxl_ts   (cancel_ts),
      .grant    (og[o]),
      .slot_flat(os[o])
    );
  end

  always_comb begin
    gv_c = '0;
    ts_c = '0;
    for (int o = 0; o < NUM_OUT; o++) begin
      for (int i = 0; i < NUM_IN; i++) begin
        if (og[o][i]) begin
          gv_c[i] = 1'b1;
          ts_c[i*TS_W +: TS_W] = os[o][i*TS_W +: TS_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= '0;
      grant_ts    <= '0;
    end else begin
      grant_valid <= gv_c;
      grant_ts    <= ts_c;
    end
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_chk
    logic [TS_W-1:0] ts_i;
    assign ts_i = grant_ts[i*TS_W +: TS_W];

    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
      grant_valid[i] |-> $past(req_valid[i])); // R3

    AST_TS_AHEAD: assert property (@(posedge clk) disable iff (rst)
      grant_valid[i] |-> TS_W'(ts_i - now) <= TS_W'(CAP - 1)); // R7
  end
endmodule

// File: tb/tb_ts_alloc_top.sv
`timescale 1ns/1ps
module tb_ts_alloc_top;
  import ts_alloc_pkg::*;

  typedef struct {
    logic [4:0]  gv;
    logic [39:0] ts;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  req_valid = '0;
  logic [14:0] req_port = '0;
  logic        cancel_valid = 1'b0;
  logic [2:0]  cancel_port = '0;
  logic [7:0]  cancel_ts = '0;
  logic [7:0]  now;
  logic [4:0]  grant_valid;
  logic [39:0] grant_ts;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  exp_t q[$];
  logic [7:0] tm = '0;
  logic       m_act[5];
  logic [7:0] m_tail[5];

  always #10 clk = ~clk;

  ts_alloc_top dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_port(req_port),
    .cancel_valid(cancel_valid), .cancel_port(cancel_port), .cancel_ts(cancel_ts),
    .now(now), .grant_valid(grant_valid), .grant_ts(grant_ts)
  );

  function automatic logic [14:0] pk(input int a, input int b, input int c, input int d, input int e);
    return {3'(e), 3'(d), 3'(c), 3'(b), 3'(a)};
  endfunction

  task automatic drive(input logic [4:0] v, input logic [14:0] p, input logic cv,
                       input logic [2:0] cp, input logic [7:0] cts, input string tag);
    exp_t       e;
    logic [7:0] base, k, s, d;
    checks++;
    if (now !== tm) begin
      errors++;
      $display("FAIL R2 now actual=%0d expected=%0d", now, tm);
    end
    req_valid = v; req_port = p; cancel_valid = cv; cancel_port = cp; cancel_ts = cts;
    e.gv = '0; e.ts = '0; e.tag = tag;
    if (cv && cp < 3'd5 && m_act[cp] && cts == m_tail[cp] && m_tail[cp] != tm) begin
      d = m_tail[cp] - tm;
      if (d == 8'd1) m_act[cp] = 1'b0;
      else           m_tail[cp] = m_tail[cp] - 8'd1;
    end
    for (int o = 0; o < 5; o++) begin
      base = m_act[o] ? m_tail[o] + 8'd1 : tm + 8'd1;
      k = '0;
      for (int i = 0; i < 5; i++) begin
        if (v[i] && p[i*3 +: 3] == 3'(o)) begin
          s = base + k;
          d = s - tm;
          if (d <= 8'd64) begin
            e.gv[i] = 1'b1;
            e.ts[i*8 +: 8] = s;
            k = k + 8'd1;
          end
        end
      end
      if (k != 0) begin
        m_act[o] = 1'b1;
        m_tail[o] = base + k - 8'd1;
      end
      if (m_act[o] && m_tail[o] == tm) m_act[o] = 1'b0;
    end
    q.push_back(e);
    tm = tm + 8'd1;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int c = 0; c < n; c++) drive('0, '0, 1'b0, '0, '0, tag);
  endtask

  // monitor: compares each registered result against the scoreboard
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      for (int i = 0; i < 5; i++) begin
        if (grant_valid[i] !== e.gv[i] ||
            (e.gv[i] && grant_ts[i*8 +: 8] !== e.ts[i*8 +: 8])) begin
          errors++;
          $display("FAIL %s input %0d actual gv=%b ts=%0d expected gv=%b ts=%0d",
                   e.tag, i, grant_valid[i], grant_ts[i*8 +: 8], e.gv[i], e.ts[i*8 +: 8]);
        end
      end
    end
  end

  initial begin
    for (int o = 0; o < 5; o++) begin m_act[o] = 1'b0; m_tail[o] = '0; end
    repeat (3) @(negedge clk);
    checks++;
    if (grant_valid !== 5'b0 || now !== 8'd0) begin
      errors++;
      $display("FAIL R1 actual gv=%b now=%0d expected gv=0 now=0", grant_valid, now);
    end
    rst = 1'b0;
    drive('0, '0, 1'b0, '0, '0, "R1");
    // R3: lone request to an idle output
    drive(5'b00001, pk(PT_NORTH, 0, 0, 0, 0), 1'b0, '0, '0, "R3");
    idle(3, "R3");
    // R5: five inputs to the same output in one cycle
    drive(5'b11111, pk(PT_EAST, PT_EAST, PT_EAST, PT_EAST, PT_EAST), 1'b0, '0, '0, "R5");
    // R4 on east, R6 on local in the same cycle
    drive(5'b01001, pk(PT_LOCAL, 0, 0, PT_EAST, 0), 1'b0, '0, '0, "R4 R6");
    // R9: cancel an older slot, then request
    drive('0, '0, 1'b1, 3'(PT_EAST), 8'd8, "R9");
    drive(5'b00010, pk(0, PT_EAST, 0, 0, 0), 1'b0, '0, '0, "R9");
    // R8: cancel newest slot, then request again
    drive('0, '0, 1'b1, 3'(PT_EAST), 8'd12, "R8");
    drive(5'b00100, pk(0, 0, PT_EAST, 0, 0), 1'b0, '0, '0, "R8");
    // R12: cancel and request in the same cycle
    drive(5'b10000, pk(0, 0, 0, 0, PT_EAST), 1'b1, 3'(PT_EAST), 8'd12, "R12");
    // R11: invalid output codes
    drive(5'b00111, pk(5, 6, 7, 0, 0), 1'b0, '0, '0, "R11");
    drive(5'b00001, pk(PT_NORTH, 0, 0, 0, 0), 1'b0, '0, '0, "R11");
    idle(12, "R6");
    // R7: saturate south until the cap refuses
    for (int c = 0; c < 20; c++)
      drive(5'b11111, pk(PT_SOUTH, PT_SOUTH, PT_SOUTH, PT_SOUTH, PT_SOUTH), 1'b0, '0, '0, "R7");
    idle(70, "R7");
    drive(5'b01000, pk(0, 0, 0, PT_SOUTH, 0), 1'b0, '0, '0, "R7");
    // R10: long mixed run across the wrap point
    for (int c = 0; c < 220; c++)
      drive(5'(5'b00001 << (c % 5)) | ((c % 3 == 0) ? 5'b10000 : 5'b0),
            pk(c % 5, (c + 1) % 5, (c + 2) % 5, c % 5, (c + 3) % 5),
            (c % 7 == 0), 3'(c % 5), tm + 8'd2, "R10");
    idle(3, "R10");
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule